// File: doc/BRIEF.md
# Overlapping-Strobe Stage Ring Sequencer

This block sets the timing of an instruction as a walk through a ring of one-hot stages. The input that paces it is a slow machine clock. The block runs on a fast system clock. It brings the machine clock in through a synchroniser and treats every level change of that clock as one tick, whether the level rises or falls. Each tick moves the ring forward by one stage, so one machine-clock cycle covers two stages.

Each stage drives two strobes:

- a short strobe, high only while that stage is the current one (one tick);
- a long strobe, high while that stage is current and for the tick after (two ticks). The long strobe overlaps the next stage's long strobe by exactly one tick.

The ring restarts at stage 1 after its last stage. An early-stop input makes it restart after stage 8 instead. A status vector repeats the short strobes of stages 1 to 8 for display, and a flag shows the early-stop input.

Reset puts the ring in a ready state. In that state only stage 1's long strobe is high. The first tick then leads to stage 2.

Top module: `stage_ring_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state is the ready state. In that state `long_o` equals 1 (only bit 0 is set), `short_o` and `stat_o` are zero, and `stop_lit_o` is 0.
- R2: Every change of `mclk_i` (rising or falling) gives exactly one stage advance. The advance shows at the outputs after the third rising edge of `clk` that follows the change. With no change, the outputs hold.
- R3: After leaving the ready state, `short_o` has exactly one bit set. That bit is bit k-1 for current stage k.
- R4: `long_o` has bit k-1 set for the current stage k and the bit of the stage just left. Stage x's long bit therefore clears when stage x+2 becomes current.
- R5: When stage N_STAGES (default 16) is current and a tick comes, stage 1 becomes current. `long_o` then shows bit 0 and bit N_STAGES-1 together.
- R6: If `stop8_i` is high when a tick leaves stage 8, the next stage is stage 1. If it is low, the next stage is stage 9.
- R7: `stop8_i` has no effect on ticks that leave any stage other than stage 8.
- R8: `stat_o` equals `short_o[7:0]`. `stop_lit_o` follows `stop8_i` one `clk` cycle later.
- R9: Reset overrides a tick that falls in the same cycle. A `mclk_i` change made while reset is held gives no advance after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mclk_i | input | 1 | Slow machine clock, asynchronous to `clk` |
| stop8_i | input | 1 | Early stop: restart after stage 8 |
| short_o | output | N_STAGES | One-tick strobe per stage |
| long_o | output | N_STAGES | Two-tick overlapping strobe per stage |
| stat_o | output | 8 | Display copy of the short strobes of stages 1 to 8 |
| stop_lit_o | output | 1 | Display flag for the early-stop input |

## Verification
Two pairs of functions can fall in the same cycle.

- **Reset and a tick.** The bench toggles the machine clock and pulls reset low right after. The pending advance and the reset then meet inside the synchroniser window. The pass condition is that the outputs show the ready state after release, and that the next change leads to stage 2.
- **Early stop and a wrap.** The early-stop level is judged at the tick that leaves stage 8. The bench holds it high and expects the ring to restart there. It holds it low and expects stage 9. It also holds it high across stages 9 to 16 and expects the wrap to come only after stage 16.

// File: rtl/seq_pkg.sv
// Package: shared types for the stage ring sequencer.
// Assumes: none; holds only the classification of machine-clock changes.
package seq_pkg;

    // Kind of machine-clock change seen in one system-clock cycle.
    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2
    } mclk_edge_e;

    // Width of the display copy of the short strobes.
    localparam int STAT_W = 8;

endpackage

// File: rtl/seq_edge_detect.sv
// Module: seq_edge_detect
// Brings the slow machine clock into the clk domain through SYNC_STAGES flops.
// Reports a rising or falling change as a one-cycle classification.
// Assumes: mclk_i stays at each level for more than SYNC_STAGES+1 clk cycles.
// The chain does not reset to a fixed value. During reset it keeps tracking
// the input, so a level held across reset release gives no false change.
module seq_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 mclk_i,
    output seq_pkg::mclk_edge_e  edge_o
);
    import seq_pkg::*;

    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q = '0;

    // First flop of the chain samples the asynchronous machine clock.
    always_ff @(posedge clk) begin
        chain_q[0] <= mclk_i;
    end

    // Each later flop copies its neighbour; the last one keeps the old level.
    for (genvar g = 1; g < CHAIN_W; g++) begin : g_sync
        always_ff @(posedge clk) begin
            chain_q[g] <= chain_q[g-1];
        end
    end

    // Compare the newest synchronised level with the one before it.
    always_comb begin
        edge_o = EDGE_NONE;
        if (chain_q[CHAIN_W-2] && !chain_q[CHAIN_W-1]) begin
            edge_o = EDGE_RISE;
        end else if (!chain_q[CHAIN_W-2] && chain_q[CHAIN_W-1]) begin
            edge_o = EDGE_FALL;
        end
    end

endmodule

// File: rtl/seq_ring_core.sv
// Module: seq_ring_core
// The one-hot stage ring. It keeps the current stage, the stage just left and
// a ready flag. A tick moves the ring forward one stage. The ring wraps to
// stage 1 after the last stage, or after stage STOP_STAGE when stop_i is high.
// Assumes: 1 <= STOP_STAGE <= N_STAGES, and N_STAGES >= 2.
module seq_ring_core #(
    parameter int N_STAGES   = 16,
    parameter int STOP_STAGE = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic                stop_i,
    output logic [N_STAGES-1:0] cur_o,
    output logic [N_STAGES-1:0] prev_o,
    output logic                ready_o
);

    localparam int LAST_IDX = N_STAGES - 1;
    localparam int STOP_IDX = STOP_STAGE - 1;

    logic [N_STAGES-1:0] cur_q;
    logic [N_STAGES-1:0] prev_q;
    logic                ready_q;
    logic                wrap;
    logic [N_STAGES-1:0] cur_next;

    // Decide whether the current stage is the one the ring ends on.
    always_comb begin
        wrap = cur_q[LAST_IDX] | (stop_i & cur_q[STOP_IDX]);
    end

    // Next one-hot position: back to stage 1 on a wrap, otherwise one step up.
    always_comb begin
        if (wrap) begin
            cur_next = {{(N_STAGES-1){1'b0}}, 1'b1};
        end else begin
            cur_next = {cur_q[N_STAGES-2:0], 1'b0};
        end
    end

    // Ring state: reset to ready, otherwise hand over one stage per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= {{(N_STAGES-1){1'b0}}, 1'b1};
            prev_q  <= '0;
            ready_q <= 1'b1;
        end else if (tick_i) begin
            cur_q   <= cur_next;
            prev_q  <= cur_q;
            ready_q <= 1'b0;
        end
    end

    assign cur_o   = cur_q;
    assign prev_o  = prev_q;
    assign ready_o = ready_q;

    // R1: a reset cycle always leads to the ready state.
    a_r1_ready_after_reset: assert property (@(posedge clk)
        !rst_n |=> (cur_q == {{(N_STAGES-1){1'b0}}, 1'b1} && prev_q == '0 && ready_q));

    // R2: with no tick, the ring holds.
    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cur_q) && $stable(prev_q));

    // R5: a tick that leaves the last stage lands on stage 1.
    a_r5_wrap_at_last: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && cur_q[LAST_IDX]) |=> (cur_q[0] && prev_q[LAST_IDX]));

    // R6: a tick that leaves the stop stage with stop high lands on stage 1.
    a_r6_stop_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && stop_i && cur_q[STOP_IDX]) |=> cur_q[0]);

    // R3: the ring position is always one-hot.
    a_r3_ring_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cur_q) == 1);

endmodule

// File: rtl/seq_strobe_out.sv
// Module: seq_strobe_out
// Forms the short and long strobes from the ring state. Also drives the
// display vector and the registered early-stop flag.
// Assumes: STAT_W <= N_STAGES.
module seq_strobe_out #(
    parameter int N_STAGES = 16,
    parameter int STAT_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_STAGES-1:0] cur_i,
    input  logic [N_STAGES-1:0] prev_i,
    input  logic                ready_i,
    input  logic                stop_i,
    output logic [N_STAGES-1:0] short_o,
    output logic [N_STAGES-1:0] long_o,
    output logic [STAT_W-1:0]   stat_o,
    output logic                stop_lit_o
);

    logic stop_lit_q;

    // Short strobe: the current stage only, suppressed in the ready state.
    always_comb begin
        short_o = ready_i ? '0 : cur_i;
    end

    // Long strobe: the current stage plus the one just left (one-tick overlap).
    always_comb begin
        long_o = cur_i | prev_i;
    end

    // Display copy of the lower short strobes.
    always_comb begin
        stat_o = short_o[STAT_W-1:0];
    end

    // Register the early-stop level for the display flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_lit_q <= 1'b0;
        end else begin
            stop_lit_q <= stop_i;
        end
    end

    assign stop_lit_o = stop_lit_q;

    // R3: never more than one short strobe at a time.
    a_r3_short_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(short_o));

    // R4: a short strobe always lies inside its long strobe.
    a_r4_short_inside_long: assert property (@(posedge clk) disable iff (!rst_n)
        (short_o & ~long_o) == '0);

    // R4: one or two long strobes, never more.
    a_r4_long_pair: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(long_o) >= 1) && ($countones(long_o) <= 2));

endmodule

// File: rtl/stage_ring_seq.sv
// Module: stage_ring_seq (top)
// A one-hot stage sequencer paced by both edges of a slow machine clock.
// Each stage gives a one-tick short strobe and a two-tick overlapping long
// strobe. An early-stop input ends the ring at stage 8.
// Assumes: mclk_i is much slower than clk; reset is held for at least
// SYNC_STAGES+1 cycles.
module stage_ring_seq #(
    parameter int N_STAGES    = 16,
    parameter int STOP_STAGE  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        mclk_i,
    input  logic                        stop8_i,
    output logic [N_STAGES-1:0]         short_o,
    output logic [N_STAGES-1:0]         long_o,
    output logic [seq_pkg::STAT_W-1:0]  stat_o,
    output logic                        stop_lit_o
);
    import seq_pkg::*;

    mclk_edge_e          edge_kind;
    logic                tick;
    logic [N_STAGES-1:0] cur;
    logic [N_STAGES-1:0] prev;
    logic                ready;

    seq_edge_detect #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk    (clk),
        .mclk_i (mclk_i),
        .edge_o (edge_kind)
    );

    // Either kind of machine-clock change is one tick.
    always_comb begin
        tick = (edge_kind != EDGE_NONE);
    end

    seq_ring_core #(
        .N_STAGES   (N_STAGES),
        .STOP_STAGE (STOP_STAGE)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .stop_i  (stop8_i),
        .cur_o   (cur),
        .prev_o  (prev),
        .ready_o (ready)
    );

    seq_strobe_out #(
        .N_STAGES (N_STAGES),
        .STAT_W   (STAT_W)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur_i      (cur),
        .prev_i     (prev),
        .ready_i    (ready),
        .stop_i     (stop8_i),
        .short_o    (short_o),
        .long_o     (long_o),
        .stat_o     (stat_o),
        .stop_lit_o (stop_lit_o)
    );

    // R2: a tick from the ready state always lands on stage 2.
    a_r2_first_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ready) |=> (short_o[1] && long_o[0] && long_o[1]));

endmodule

// File: tb/stage_ring_seq_tb_top.sv
module stage_ring_seq_tb_top;

    localparam int N  = 16;
    localparam int SP = 8;

    typedef struct {
        logic [N-1:0] sh;
        logic [N-1:0] lg;
        logic [7:0]   st;
        logic         ab;
        int           due;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mclk = 1'b0;
    logic         stop8 = 1'b0;
    logic [N-1:0] short_w;
    logic [N-1:0] long_w;
    logic [7:0]   stat_w;
    logic         lit_w;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;
    exp_t q[$];

    // Bench model of the ring: current stage, stage left, ready flag.
    int m_cur  = 1;
    int m_prev = 0;
    bit m_rdy  = 1'b1;

    always #5 clk = ~clk;

    stage_ring_seq dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mclk_i     (mclk),
        .stop8_i    (stop8),
        .short_o    (short_w),
        .long_o     (long_w),
        .stat_o     (stat_w),
        .stop_lit_o (lit_w)
    );

    function automatic exp_t model_exp(string tag, int due);
        exp_t e;
        logic [N-1:0] cur1h;
        cur1h  = N'(1) << (m_cur - 1);
        e.sh   = m_rdy ? '0 : cur1h;
        e.lg   = cur1h | ((m_prev > 0) ? (N'(1) << (m_prev - 1)) : '0);
        e.st   = e.sh[7:0];
        e.ab   = stop8;
        e.due  = due;
        e.tag  = tag;
        return e;
    endfunction

    task automatic compare(exp_t e);
        vectors++;
        if (short_w !== e.sh || long_w !== e.lg || stat_w !== e.st || lit_w !== e.ab) begin
            fails++;
            $display("FAIL %s R8: short=%h long=%h stat=%h lit=%b expected short=%h long=%h stat=%h lit=%b",
                     e.tag, short_w, long_w, stat_w, lit_w, e.sh, e.lg, e.st, e.ab);
        end
    endtask

    // Monitor: pops each expected item at the cycle it falls due.
    always @(negedge clk) begin
        cyc++;
        if (q.size() > 0 && q[0].due == cyc) begin
            compare(q.pop_front());
        end
    end

    // Driver: one machine-clock change, model update, push expectation.
    task automatic mstep();
        string tag;
        @(posedge clk); #1;
        mclk = ~mclk;
        m_prev = m_cur;
        m_rdy  = 1'b0;
        if (m_cur == N) begin
            m_cur = 1; tag = "R5";
        end else if (stop8 && m_cur == SP) begin
            m_cur = 1; tag = "R6";
        end else begin
            tag = (m_cur == SP) ? "R6" : (stop8 ? "R7" : "R2 R3 R4");
            m_cur = m_cur + 1;
        end
        q.push_back(model_exp(tag, cyc + 4));
        repeat (6) @(posedge clk);
    endtask

    task automatic check_now(string tag);
        @(negedge clk); #1;
        compare(model_exp(tag, 0));
    endtask

    task automatic model_reset();
        m_cur = 1; m_prev = 0; m_rdy = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R2: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(posedge clk);
        check_now("R1");
        // Hold: no change on mclk, outputs stay in the ready state (R2).
        repeat (5) @(posedge clk);
        check_now("R2");

        // Full walk with no early stop, including the wrap after stage 16 (R5).
        for (int i = 0; i < N + 1; i++) mstep();

        // Early stop high: stages 3..8 unaffected (R7), then restart (R6).
        @(posedge clk); #1 stop8 = 1'b1;
        repeat (2) @(posedge clk);
        check_now("R8");
        for (int i = 0; i < 7; i++) mstep();

        // Early stop low at stage 8: continue to stage 9 (R6).
        @(posedge clk); #1 stop8 = 1'b0;
        repeat (2) @(posedge clk);
        check_now("R8");
        for (int i = 0; i < 8; i++) mstep();

        // Early stop high at stages 9..16: no effect until the last stage (R7, R5).
        @(posedge clk); #1 stop8 = 1'b1;
        repeat (2) @(posedge clk);
        for (int i = 0; i < 8; i++) mstep();
        @(posedge clk); #1 stop8 = 1'b0;
        repeat (4) @(posedge clk);

        // Reset in the same window as a tick: reset wins, no late step (R9).
        mstep();
        @(posedge clk); #1;
        mclk  = ~mclk;
        rst_n = 1'b0;
        model_reset();
        repeat (6) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (8) @(posedge clk);
        check_now("R9");
        mstep();
        repeat (6) @(posedge clk);
        check_now("R9");

        repeat (4) @(posedge clk);
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R2: %0d expectations left pending, expected 0", q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule